// File: doc/BRIEF.md
# Packet-Aware Transmit and Receive Byte Buffers

This block holds two byte-wide, first-in first-out stores, one per direction, between a host register port and a link-layer datapath. The host fills the transmit store with burst write strobes, and the outgoing datapath takes bytes with a pop handshake. The incoming datapath delivers bytes with a push handshake, and the host empties the receive store with burst read strobes. Each store holds 16 bytes by default. A packet may carry up to 40 payload bytes, so a long packet streams through the store while the host refills or drains it.

Both directions count bytes against one programmed packet length. Level interrupts tell the host when the transmit store has room (occupancy at or below a low watermark) and when the receive store needs draining (occupancy at or above a high watermark). Sticky flags record a finished transmit packet, a transmit underrun and a receive overflow. A host acknowledge clears the sticky flags and restarts the byte counts. A flush per direction empties that store in one cycle.

Top module: `pktbuf_top`

## Requirements
- R1: After reset both levels are 0, link_tx_valid is 0 and irq_tx_done, irq_tx_underrun and irq_rx_overflow are 0.
- R2: Bytes written by the host leave on link_tx_data in write order. link_tx_data shows the oldest byte while link_tx_valid is 1, and each accepted pop moves to the next byte.
- R3: A host write while the transmit store holds 16 bytes is ignored. The level stays 16 and the stored bytes are unchanged.
- R4: Once cfg_pkt_len bytes of the current packet have been popped, link_tx_valid goes to 0 and further pops leave the store untouched. irq_tx_done reads 1 in the cycle after the pop that completed the packet.
- R5: A pop while the transmit store is empty and the packet is not complete sets irq_tx_underrun, which stays set until cleared.
- R6: host_ack clears irq_tx_done, irq_tx_underrun and irq_rx_overflow, and restarts both byte counts at zero.
- R7: Bytes pushed by the link reach host_rd_data in push order. host_rd_data shows the oldest byte, and each host read removes one.
- R8: A push that arrives while the receive store is full, with the packet incomplete, is dropped. irq_rx_overflow is set and the level stays 16.
- R9: Once cfg_pkt_len bytes have been pushed (dropped ones included), further pushes are ignored and do not set irq_rx_overflow.
- R10: irq_tx_space equals (tx_level <= cfg_tx_low_wm). irq_rx_data equals (rx_level >= cfg_rx_high_wm).
- R11: A flush empties its store in one cycle and restarts that direction's byte count. tx_flush also clears irq_tx_done and irq_tx_underrun, and rx_flush clears irq_rx_overflow.
- R12: A 40-byte packet passes through each 16-byte store without loss or reordering when the host refills on irq_tx_space and drains on irq_rx_data.
- R13: A host read while the receive store is empty is ignored and moves no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pkt_len | input | 6 | Payload bytes per packet (0 to 40) |
| cfg_tx_low_wm | input | 5 | Transmit low watermark |
| cfg_rx_high_wm | input | 5 | Receive high watermark |
| tx_flush | input | 1 | Empty transmit store and restart its count |
| rx_flush | input | 1 | Empty receive store and restart its count |
| host_ack | input | 1 | Clear sticky flags and restart both counts |
| host_wr_en | input | 1 | Host write strobe into transmit store |
| host_wr_data | input | 8 | Host write byte |
| host_rd_en | input | 1 | Host read strobe from receive store |
| host_rd_data | output | 8 | Oldest byte in receive store |
| tx_level | output | 5 | Transmit occupancy |
| rx_level | output | 5 | Receive occupancy |
| link_tx_pop | input | 1 | Outgoing datapath takes a byte |
| link_tx_valid | output | 1 | A byte of the current packet is ready |
| link_tx_data | output | 8 | Oldest byte in transmit store |
| link_rx_push | input | 1 | Incoming datapath delivers a byte |
| link_rx_data | input | 8 | Incoming byte |
| irq_tx_space | output | 1 | Transmit occupancy at or below low watermark |
| irq_rx_data | output | 1 | Receive occupancy at or above high watermark |
| irq_tx_done | output | 1 | Sticky: transmit packet complete |
| irq_tx_underrun | output | 1 | Sticky: pop with empty store mid-packet |
| irq_rx_overflow | output | 1 | Sticky: push dropped on full store |

## Verification
The bench drives each watermark comparison at its equality points, where an off-by-one compare would flip an interrupt. It overfills both stores. A design that wrapped a pointer on a full write would corrupt the oldest byte, and one that lost the overflow flag would hide the dropped byte. It pops past the packet end and reads an empty receive store. A counter that ignored the length would leak the next packet's bytes, and a read that moved the pointer when empty would shift later data. Two 40-byte streams, refilled and drained on the interrupts, catch any loss or reordering across pointer wrap.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  // Ring index advance with wrap at the store depth.
  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // Occupancy after one cycle of optional insert and optional remove.
  function automatic int unsigned occ_next(int unsigned occ, logic put, logic take);
    return occ + (put ? 1 : 0) - (take ? 1 : 0);
  endfunction

  // Low watermark test: room for the host to refill.
  function automatic logic at_or_below(int unsigned lvl, int unsigned mark);
    return lvl <= mark;
  endfunction

  // High watermark test: enough held for the host to drain.
  function automatic logic at_or_above(int unsigned lvl, int unsigned mark);
    return lvl >= mark;
  endfunction

endpackage

// File: rtl/pktbuf_fifo.sv
module pktbuf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         wr,
  input  logic [W-1:0]                 wdata,
  input  logic                         rd,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  // Named events for the assertions
  logic wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign wr_ok = wr && !full && !flush;
  assign rd_ok = rd && !empty && !flush;
  assign rdata = mem[rd_ptr];
  assign level = count;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= PTR_W'(pktbuf_pkg::ring_next(32'(wr_ptr), DEPTH));
      if (rd_ok) rd_ptr <= PTR_W'(pktbuf_pkg::ring_next(32'(rd_ptr), DEPTH));
      count <= CNT_W'(pktbuf_pkg::occ_next(32'(count), wr_ok, rd_ok));
    end
  end

  // R3: occupancy never passes the depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: a write into a full store with no read leaves it full
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr && !rd && !flush) |=> full);

  // R11: flush empties in one cycle
  a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R2: a lone read drops occupancy by one
  a_r2_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !wr_ok) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/pktbuf_len_counter.sv
module pktbuf_len_counter #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic             complete,
  output logic             last
);
  logic [LEN_W-1:0] cnt;

  assign complete = (cnt >= len);
  assign last     = step && !complete && (cnt + LEN_W'(1) == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (step && !complete)    cnt <= cnt + LEN_W'(1);
  end

  // R4/R9: a complete count does not advance
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !clr) |=> (cnt == $past(cnt)));

  // R6/R11: clear restarts at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/pktbuf_top.sv
module pktbuf_top #(
  parameter int W       = 8,
  parameter int DEPTH   = 16,
  parameter int MAX_LEN = 40,
  localparam int LEN_W  = $clog2(MAX_LEN+1),
  localparam int CNT_W  = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [CNT_W-1:0] cfg_tx_low_wm,
  input  logic [CNT_W-1:0] cfg_rx_high_wm,
  input  logic             tx_flush,
  input  logic             rx_flush,
  input  logic             host_ack,
  input  logic             host_wr_en,
  input  logic [W-1:0]     host_wr_data,
  input  logic             host_rd_en,
  output logic [W-1:0]     host_rd_data,
  output logic [CNT_W-1:0] tx_level,
  output logic [CNT_W-1:0] rx_level,
  input  logic             link_tx_pop,
  output logic             link_tx_valid,
  output logic [W-1:0]     link_tx_data,
  input  logic             link_rx_push,
  input  logic [W-1:0]     link_rx_data,
  output logic             irq_tx_space,
  output logic             irq_rx_data,
  output logic             irq_tx_done,
  output logic             irq_tx_underrun,
  output logic             irq_rx_overflow
);
  // Store status
  logic tx_empty, tx_full, rx_empty, rx_full;
  // Packet progress
  logic tx_complete, tx_last, rx_complete, rx_last;
  // Named events
  logic tx_pop_ok, tx_underrun_ev, rx_take, rx_store, rx_ovf_ev;
  logic tx_clr, rx_clr;

  assign tx_clr = tx_flush | host_ack;
  assign rx_clr = rx_flush | host_ack;

  assign tx_pop_ok      = link_tx_pop && !tx_empty && !tx_complete;
  assign tx_underrun_ev = link_tx_pop &&  tx_empty && !tx_complete;
  assign rx_take        = link_rx_push && !rx_complete;
  assign rx_store       = rx_take && !rx_full;
  assign rx_ovf_ev      = rx_take &&  rx_full;

  pktbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_store (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .wr(host_wr_en), .wdata(host_wr_data),
    .rd(tx_pop_ok), .rdata(link_tx_data),
    .level(tx_level), .empty(tx_empty), .full(tx_full)
  );

  pktbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_store (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .wr(rx_store), .wdata(link_rx_data),
    .rd(host_rd_en), .rdata(host_rd_data),
    .level(rx_level), .empty(rx_empty), .full(rx_full)
  );

  pktbuf_len_counter #(.LEN_W(LEN_W)) u_tx_count (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr), .step(tx_pop_ok),
    .len(cfg_pkt_len), .complete(tx_complete), .last(tx_last)
  );

  pktbuf_len_counter #(.LEN_W(LEN_W)) u_rx_count (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr), .step(rx_take),
    .len(cfg_pkt_len), .complete(rx_complete), .last(rx_last)
  );

  assign link_tx_valid = !tx_empty && !tx_complete;
  assign irq_tx_space  = pktbuf_pkg::at_or_below(32'(tx_level), 32'(cfg_tx_low_wm));
  assign irq_rx_data   = pktbuf_pkg::at_or_above(32'(rx_level), 32'(cfg_rx_high_wm));

  // Sticky flags: a clear in the same cycle takes priority
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_tx_done     <= 1'b0;
      irq_tx_underrun <= 1'b0;
      irq_rx_overflow <= 1'b0;
    end else begin
      if (tx_clr)              irq_tx_done <= 1'b0;
      else if (tx_last)        irq_tx_done <= 1'b1;
      if (tx_clr)              irq_tx_underrun <= 1'b0;
      else if (tx_underrun_ev) irq_tx_underrun <= 1'b1;
      if (rx_clr)              irq_rx_overflow <= 1'b0;
      else if (rx_ovf_ev)      irq_rx_overflow <= 1'b1;
    end
  end

  // R4: the completing pop raises done on the next cycle
  a_r4_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last && !tx_clr) |=> irq_tx_done);

  // R4: no byte is offered once the packet is complete
  a_r4_no_valid_after: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_done |-> !link_tx_valid);

  // R5: underrun stays set until a clear
  a_r5_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx_underrun && !tx_clr) |=> irq_tx_underrun);

  // R8: a dropped push leaves the receive store full
  a_r8_overflow_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_ev && !rx_clr && !host_rd_en) |=> (rx_level == CNT_W'(DEPTH) && irq_rx_overflow));

  // R9: the last counted push completes the receive count
  a_r9_rx_last_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_last && !rx_clr) |=> rx_complete);

  // R6: acknowledge clears every sticky flag
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> (!irq_tx_done && !irq_tx_underrun && !irq_rx_overflow));

endmodule

// File: tb/pktbuf_top_tb.sv
`timescale 1ns/1ps
module pktbuf_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_pkt_len = 6'd40;
  logic [4:0] cfg_tx_low_wm = 5'd0, cfg_rx_high_wm = 5'd0;
  logic       tx_flush = 0, rx_flush = 0, host_ack = 0;
  logic       host_wr_en = 0, host_rd_en = 0;
  logic [7:0] host_wr_data = 0, host_rd_data;
  logic [4:0] tx_level, rx_level;
  logic       link_tx_pop = 0, link_tx_valid;
  logic [7:0] link_tx_data;
  logic       link_rx_push = 0;
  logic [7:0] link_rx_data = 0;
  logic       irq_tx_space, irq_rx_data, irq_tx_done, irq_tx_underrun, irq_rx_overflow;

  int tests = 0;
  int fails = 0;

  pktbuf_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_pkt_len(cfg_pkt_len),
    .cfg_tx_low_wm(cfg_tx_low_wm), .cfg_rx_high_wm(cfg_rx_high_wm),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .host_ack(host_ack),
    .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
    .tx_level(tx_level), .rx_level(rx_level),
    .link_tx_pop(link_tx_pop), .link_tx_valid(link_tx_valid), .link_tx_data(link_tx_data),
    .link_rx_push(link_rx_push), .link_rx_data(link_rx_data),
    .irq_tx_space(irq_tx_space), .irq_rx_data(irq_rx_data), .irq_tx_done(irq_tx_done),
    .irq_tx_underrun(irq_tx_underrun), .irq_rx_overflow(irq_rx_overflow)
  );

  always #2 clk = ~clk;

  // Vector fields: [16:12] bytes in, [11:7] low wm, [6:2] high wm, [1] space, [0] data
  localparam logic [16:0] VEC [7] = '{
    {5'd0,  5'd0,  5'd0,  1'b1, 1'b1},
    {5'd1,  5'd0,  5'd1,  1'b0, 1'b1},
    {5'd4,  5'd4,  5'd5,  1'b1, 1'b0},
    {5'd5,  5'd4,  5'd5,  1'b0, 1'b1},
    {5'd16, 5'd15, 5'd16, 1'b0, 1'b1},
    {5'd16, 5'd16, 5'd16, 1'b1, 1'b1},
    {5'd10, 5'd12, 5'd11, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic flush_both();
    @(negedge clk); tx_flush = 1; rx_flush = 1;
    @(negedge clk); tx_flush = 0; rx_flush = 0;
  endtask

  task automatic ack();
    @(negedge clk); host_ack = 1;
    @(negedge clk); host_ack = 0;
  endtask

  task automatic host_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); host_wr_en = 1; host_wr_data = 8'(base + i);
    end
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic link_burst(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); link_rx_push = 1; link_rx_data = 8'(base + i);
    end
    @(negedge clk); link_rx_push = 0;
  endtask

  task automatic pop_one();
    @(negedge clk); link_tx_pop = 1;
    @(negedge clk); link_tx_pop = 0;
  endtask

  task automatic read_one();
    @(negedge clk); host_rd_en = 1;
    @(negedge clk); host_rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int mism, popped, written, pushed, got;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_level", tx_level, 0);
    chk("R1 rx_level", rx_level, 0);
    chk("R1 link_tx_valid", link_tx_valid, 0);
    chk("R1 sticky flags", {irq_tx_done, irq_tx_underrun, irq_rx_overflow}, 0);

    // R10 watermark vectors
    foreach (VEC[k]) begin
      flush_both();
      cfg_pkt_len = 6'd40;
      cfg_tx_low_wm = VEC[k][11:7];
      cfg_rx_high_wm = VEC[k][6:2];
      for (int i = 0; i < int'(VEC[k][16:12]); i++) begin
        @(negedge clk); host_wr_en = 1; host_wr_data = 8'(i);
        link_rx_push = 1; link_rx_data = 8'(i);
      end
      @(negedge clk); host_wr_en = 0; link_rx_push = 0;
      chk("R10 tx_level", tx_level, int'(VEC[k][16:12]));
      chk("R10 irq_tx_space", irq_tx_space, VEC[k][1]);
      chk("R10 irq_rx_data", irq_rx_data, VEC[k][0]);
    end

    // R2 / R4 ordered packet of 5 bytes
    flush_both(); ack();
    cfg_pkt_len = 6'd5; cfg_tx_low_wm = 5'd4; cfg_rx_high_wm = 5'd8;
    host_burst(5, 8'h10);
    chk("R2 tx_level after burst", tx_level, 5);
    mism = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (link_tx_data != 8'(8'h10 + i) || !link_tx_valid) mism++;
      link_tx_pop = 1;
    end
    @(negedge clk); link_tx_pop = 0;
    chk("R2 tx byte order", mism, 0);
    chk("R4 irq_tx_done", irq_tx_done, 1);
    chk("R4 valid after packet", link_tx_valid, 0);
    host_burst(1, 8'h77);
    pop_one();
    chk("R4 pop after packet ignored", tx_level, 1);
    chk("R4 no underrun when complete", irq_tx_underrun, 0);

    // R6 ack restarts count; R5 underrun
    ack();
    chk("R6 done cleared", irq_tx_done, 0);
    chk("R6 restarted count, head byte", link_tx_data, 8'h77);
    chk("R6 valid after restart", link_tx_valid, 1);
    pop_one();
    chk("R6 pop accepted", tx_level, 0);
    pop_one();
    chk("R5 underrun set", irq_tx_underrun, 1);
    repeat (3) @(negedge clk);
    chk("R5 underrun sticky", irq_tx_underrun, 1);
    ack();
    chk("R6 underrun cleared", irq_tx_underrun, 0);

    // R3 overfill transmit store
    flush_both(); ack(); cfg_pkt_len = 6'd40;
    host_burst(20, 8'h40);
    chk("R3 tx_level full", tx_level, 16);
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (link_tx_data != 8'(8'h40 + i)) mism++;
      link_tx_pop = 1;
    end
    @(negedge clk); link_tx_pop = 0;
    chk("R3 stored bytes unchanged", mism, 0);
    chk("R3 drained", tx_level, 0);

    // R8 overflow, R7 order, R13 empty read
    flush_both(); ack();
    link_burst(18, 8'h80);
    chk("R8 rx_level full", rx_level, 16);
    chk("R8 overflow flag", irq_rx_overflow, 1);
    mism = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (host_rd_data != 8'(8'h80 + i)) mism++;
      host_rd_en = 1;
    end
    @(negedge clk); host_rd_en = 0;
    chk("R7 rx byte order", mism, 0);
    read_one();
    chk("R13 empty read level", rx_level, 0);
    link_burst(1, 8'hAA);
    chk("R13 pointer kept", host_rd_data, 8'hAA);
    chk("R13 level after push", rx_level, 1);

    // R9 pushes past packet length
    flush_both(); ack(); cfg_pkt_len = 6'd3;
    link_burst(5, 8'h30);
    chk("R9 rx_level capped by length", rx_level, 3);
    chk("R9 no overflow", irq_rx_overflow, 0);

    // R11 flush with content and flags
    cfg_pkt_len = 6'd40;
    host_burst(4, 8'h01);
    link_burst(16, 8'h00);
    link_burst(1, 8'h00);
    chk("R11 overflow before flush", irq_rx_overflow, 1);
    flush_both();
    chk("R11 tx_level", tx_level, 0);
    chk("R11 rx_level", rx_level, 0);
    chk("R11 overflow cleared", irq_rx_overflow, 0);
    chk("R11 valid cleared", link_tx_valid, 0);

    // R12 transmit stream of 40 bytes
    flush_both(); ack(); cfg_pkt_len = 6'd40; cfg_tx_low_wm = 5'd4;
    host_burst(16, 0);
    written = 16; popped = 0; mism = 0;
    for (int c = 0; c < 400 && popped < 40; c++) begin
      @(negedge clk);
      link_tx_pop = 0; host_wr_en = 0;
      if (link_tx_valid) begin
        if (link_tx_data != 8'(popped)) mism++;
        link_tx_pop = 1; popped++;
      end
      if (irq_tx_space && written < 40 && tx_level < 16) begin
        host_wr_en = 1; host_wr_data = 8'(written); written++;
      end
    end
    @(negedge clk); link_tx_pop = 0; host_wr_en = 0;
    chk("R12 tx bytes in order", mism, 0);
    chk("R12 tx bytes out", popped, 40);
    chk("R12 tx done", irq_tx_done, 1);
    chk("R12 tx no underrun", irq_tx_underrun, 0);

    // R12 receive stream of 40 bytes
    flush_both(); ack(); cfg_rx_high_wm = 5'd8;
    pushed = 0; got = 0; mism = 0;
    for (int c = 0; c < 400 && got < 40; c++) begin
      @(negedge clk);
      link_rx_push = 0; host_rd_en = 0;
      if (rx_level > 0 && (irq_rx_data || pushed == 40)) begin
        if (host_rd_data != 8'(8'h20 + got)) mism++;
        host_rd_en = 1; got++;
      end
      if (pushed < 40) begin
        link_rx_push = 1; link_rx_data = 8'(8'h20 + pushed); pushed++;
      end
    end
    @(negedge clk); link_rx_push = 0; host_rd_en = 0;
    chk("R12 rx bytes in order", mism, 0);
    chk("R12 rx bytes read", got, 40);
    chk("R12 rx no overflow", irq_rx_overflow, 0);

    finish_run();
  end
endmodule